// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a single memory access may proceed. Each request carries a byte address, an access kind (read, write or instruction fetch) and the privilege level of the requester: Machine or User. The block compares the address against eight protection regions and returns one allow-or-deny answer per request. Each region has a configuration byte and an address register, and both are held inside the block.

A region can be locked. A locked region binds Machine mode to its permission bits as well, and it refuses further writes to its own registers until reset. In the TOR address mode, a locked region also protects the address register of the region below it, because that register forms its lower bound.

A sticky extended-protection enable changes what the lock bit means. With the enable set, an unlocked region becomes a User-only rule that Machine mode may not touch, and a locked region becomes a Machine-only rule. Software writes the registers through per-region write strobes, and reads them back on flat output buses. Per-region write-permission outputs let the surrounding register file report when a write was dropped.

Top module: `pmp_guard`

## Requirements
- R1: While no region has an active address mode (configuration bits 4:3 equal 00 or 10 in every region), every access is allowed at either privilege level.
- R2: While at least one region is active, an access that matches no region is denied in User mode (`req_priv_i`=0) and allowed in Machine mode (`req_priv_i`=1).
- R3: With extended protection off, a match on an unlocked region (bit 7 clear) uses that region's permission bits for User mode and is always allowed for Machine mode.
- R4: With extended protection off, a match on a locked region (bit 7 set) uses its permission bits in Machine mode as well.
- R5: A locked region ignores writes to its configuration byte and its address register, and its `cfg_wr_ok_o` and `addr_wr_ok_o` bits read 0. Only reset clears the lock.
- R6: When region i+1 is locked and set to TOR (bits 4:3 = 01), the address register of region i ignores writes and its `addr_wr_ok_o` bit reads 0.
- R7: The access kind `req_type_i` selects the permission bit it is checked against: 00 read uses bit 0, 01 write uses bit 1, 10 fetch uses bit 2. Kind 11 is denied whenever a matched rule is consulted.
- R8: When several regions match, the region with the lowest index alone decides the result.
- R9: The address registers hold word addresses (byte address bits 31:2). In TOR mode, region i matches words w with addr[i-1] <= w < addr[i], where the lower bound is 0 for region 0. In NAPOT mode (bits 4:3 = 11), an address register with k trailing ones covers an aligned block of 2^(k+3) bytes.
- R10: Writing 1 on `sec_wdata_i` with `sec_we_i` sets the extended-protection enable. A write of 0 leaves it set, and only reset clears it.
- R11: With extended protection on, a matched unlocked region is denied to Machine mode and uses its permission bits for User mode. A matched locked region uses its permission bits for Machine mode and is denied to User mode.
- R12: `rsp_valid_o` is high exactly in the cycle after `req_valid_i`. `rsp_allow_o` carries the decision made from the register state at the request cycle, and it is 0 when there is no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 8 | Per-region configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration byte to write |
| addr_we_i | input | 8 | Per-region address write strobe |
| addr_wdata_i | input | 30 | Word address to write |
| sec_we_i | input | 1 | Extended-protection register write strobe |
| sec_wdata_i | input | 1 | Extended-protection enable value |
| req_valid_i | input | 1 | Access request present |
| req_addr_i | input | 32 | Byte address of the access |
| req_type_i | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| req_priv_i | input | 1 | 1 Machine mode, 0 User mode |
| rsp_valid_o | output | 1 | Decision present |
| rsp_allow_o | output | 1 | 1 access allowed, 0 denied |
| cfg_wr_ok_o | output | 8 | Per-region configuration writable |
| addr_wr_ok_o | output | 8 | Per-region address writable |
| cfg_rd_o | output | 64 | All configuration bytes, region i at bits 8i+7:8i |
| addr_rd_o | output | 240 | All address registers, region i at bits 30i+29:30i |
| sec_en_o | output | 1 | Extended-protection enable state |

## Verification
The hardest situation to reach is a layered one: a locked TOR region guarding its neighbour's address, with overlapping regions of different priority, and then the extended enable flipping the meaning of lock bits that are already fixed. The bench gets there by building the region set in stages. It checks the plain rules first, then locks regions one at a time and attempts writes that must be dropped. Only after that does it set the sticky enable, so the same regions and addresses are checked again under the inverted rules. A final reset shows that locks and the enable are cleared.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'b00,
        AM_TOR   = 2'b01,
        AM_NA4   = 2'b10,
        AM_NAPOT = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    localparam int CFG_R    = 0;
    localparam int CFG_W    = 1;
    localparam int CFG_X    = 2;
    localparam int CFG_AMLO = 3;
    localparam int CFG_LOCK = 7;

endpackage

// File: rtl/pmp_region_match.sv
module pmp_region_match
    import pmp_guard_pkg::*;
#(
    parameter int WW = 30
) (
    input  logic [7:0]    cfg_i,
    input  logic [WW-1:0] base_i,
    input  logic [WW-1:0] top_i,
    input  logic [WW-1:0] word_i,
    output logic          en_o,
    output logic          hit_o
);

    amode_e        mode;
    logic [WW-1:0] napot_mask;

    always_comb begin
        mode       = amode_e'(cfg_i[CFG_AMLO +: 2]);
        // ones up to and including the lowest zero of the register
        napot_mask = top_i ^ (top_i + WW'(1));
        en_o       = (mode == AM_TOR) || (mode == AM_NAPOT);
        unique case (mode)
            AM_TOR:   hit_o = (word_i >= base_i) && (word_i < top_i);
            AM_NAPOT: hit_o = ((word_i | napot_mask) == (top_i | napot_mask));
            default:  hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmp_rule_decide.sv
module pmp_rule_decide
    import pmp_guard_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic [NREG-1:0]   hit_i,
    input  logic [NREG-1:0]   en_i,
    input  logic [NREG*8-1:0] cfg_i,
    input  logic              priv_m_i,
    input  logic [1:0]        acc_i,
    input  logic              xmode_i,
    output logic              allow_o
);

    logic       found;
    logic [7:0] sel;
    logic       perm;
    logic       locked;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        // walk downward so the lowest matching index wins
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                found = 1'b1;
                sel   = cfg_i[i*8 +: 8];
            end
        end

        unique case (acc_e'(acc_i))
            ACC_READ:  perm = sel[CFG_R];
            ACC_WRITE: perm = sel[CFG_W];
            ACC_EXEC:  perm = sel[CFG_X];
            default:   perm = 1'b0;
        endcase
        locked = sel[CFG_LOCK];

        if (en_i == '0) begin
            allow_o = 1'b1;
        end else if (!found) begin
            allow_o = priv_m_i;
        end else if (!xmode_i) begin
            allow_o = (priv_m_i && !locked) ? 1'b1 : perm;
        end else if (locked) begin
            allow_o = priv_m_i ? perm : 1'b0;
        end else begin
            allow_o = priv_m_i ? 1'b0 : perm;
        end
    end

endmodule

// File: rtl/pmp_write_gate.sv
module pmp_write_gate
    import pmp_guard_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic [NREG*8-1:0] cfg_i,
    output logic [NREG-1:0]   cfg_ok_o,
    output logic [NREG-1:0]   addr_ok_o
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic own_lock;
        logic upper_guard;

        assign own_lock = cfg_i[i*8 + CFG_LOCK];

        if (i < NREG - 1) begin : g_upper
            assign upper_guard = cfg_i[(i+1)*8 + CFG_LOCK] &&
                (amode_e'(cfg_i[(i+1)*8 + CFG_AMLO +: 2]) == AM_TOR);
        end else begin : g_top
            assign upper_guard = 1'b0;
        end

        assign cfg_ok_o[i]  = !own_lock;
        assign addr_ok_o[i] = !own_lock && !upper_guard;
    end

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
    import pmp_guard_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NREG-1:0]          cfg_we_i,
    input  logic [7:0]               cfg_wdata_i,
    input  logic [NREG-1:0]          addr_we_i,
    input  logic [AW-3:0]            addr_wdata_i,
    input  logic                     sec_we_i,
    input  logic                     sec_wdata_i,
    input  logic                     req_valid_i,
    input  logic [AW-1:0]            req_addr_i,
    input  logic [1:0]               req_type_i,
    input  logic                     req_priv_i,
    output logic                     rsp_valid_o,
    output logic                     rsp_allow_o,
    output logic [NREG-1:0]          cfg_wr_ok_o,
    output logic [NREG-1:0]          addr_wr_ok_o,
    output logic [NREG*8-1:0]        cfg_rd_o,
    output logic [NREG*(AW-2)-1:0]   addr_rd_o,
    output logic                     sec_en_o
);

    localparam int WW = AW - 2;

    typedef struct packed {
        logic [NREG-1:0][7:0]    cfg;
        logic [NREG-1:0][WW-1:0] addr;
        logic                    xmode;
        logic                    rsp_valid;
        logic                    rsp_allow;
    } state_t;

    state_t state_d, state_q;

    logic [NREG*8-1:0]  cfg_flat;
    logic [NREG*WW-1:0] addr_flat;
    logic [NREG-1:0]    cfg_ok, addr_ok;
    logic [NREG-1:0]    reg_en, reg_hit;
    logic [WW-1:0]      req_word;
    logic               allow;

    assign cfg_flat  = state_q.cfg;
    assign addr_flat = state_q.addr;
    assign req_word  = req_addr_i[AW-1:2];

    pmp_write_gate #(.NREG(NREG)) u_gate (
        .cfg_i     (cfg_flat),
        .cfg_ok_o  (cfg_ok),
        .addr_ok_o (addr_ok)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_match
        logic [WW-1:0] base;
        if (i == 0) begin : g_first
            assign base = '0;
        end else begin : g_rest
            assign base = addr_flat[(i-1)*WW +: WW];
        end

        pmp_region_match #(.WW(WW)) u_match (
            .cfg_i  (cfg_flat[i*8 +: 8]),
            .base_i (base),
            .top_i  (addr_flat[i*WW +: WW]),
            .word_i (req_word),
            .en_o   (reg_en[i]),
            .hit_o  (reg_hit[i])
        );
    end

    pmp_rule_decide #(.NREG(NREG)) u_decide (
        .hit_i    (reg_hit),
        .en_i     (reg_en),
        .cfg_i    (cfg_flat),
        .priv_m_i (req_priv_i),
        .acc_i    (req_type_i),
        .xmode_i  (state_q.xmode),
        .allow_o  (allow)
    );

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NREG; i++) begin
            if (cfg_we_i[i] && cfg_ok[i]) begin
                state_d.cfg[i] = cfg_wdata_i;
            end
            if (addr_we_i[i] && addr_ok[i]) begin
                state_d.addr[i] = addr_wdata_i;
            end
        end
        if (sec_we_i && sec_wdata_i) begin
            state_d.xmode = 1'b1;
        end
        state_d.rsp_valid = req_valid_i;
        state_d.rsp_allow = req_valid_i && allow;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid_o  = state_q.rsp_valid;
    assign rsp_allow_o  = state_q.rsp_allow;
    assign cfg_wr_ok_o  = cfg_ok;
    assign addr_wr_ok_o = addr_ok;
    assign cfg_rd_o     = cfg_flat;
    assign addr_rd_o    = addr_flat;
    assign sec_en_o     = state_q.xmode;

endmodule

// File: rtl/pmp_guard_chk.sv
module pmp_guard_chk #(
    parameter int NREG = 8,
    parameter int AW   = 32
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   req_valid_i,
    input logic                   rsp_valid_o,
    input logic                   rsp_allow_o,
    input logic [NREG-1:0]        cfg_wr_ok_o,
    input logic [NREG-1:0]        addr_wr_ok_o,
    input logic [NREG*8-1:0]      cfg_rd_o,
    input logic [NREG*(AW-2)-1:0] addr_rd_o,
    input logic                   sec_en_o
);

    localparam int WW = AW - 2;

    logic none_active;
    always_comb begin
        none_active = 1'b1;
        for (int i = 0; i < NREG; i++) begin
            if (cfg_rd_o[i*8 + 3]) none_active = 1'b0;
        end
    end

    p_open_default_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i && none_active |=> rsp_allow_o);

    p_rsp_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);

    p_rsp_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o && !rsp_allow_o);

    p_sticky_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_en_o |=> sec_en_o);

    for (genvar i = 0; i < NREG; i++) begin : g_chk
        p_lock_cfg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cfg_rd_o[i*8 + 7] |=> $stable(cfg_rd_o[i*8 +: 8]));

        p_lock_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cfg_rd_o[i*8 + 7] |=> $stable(addr_rd_o[i*WW +: WW]));

        p_lock_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cfg_rd_o[i*8 + 7] |-> !cfg_wr_ok_o[i] && !addr_wr_ok_o[i]);

        if (i < NREG - 1) begin : g_nb
            p_tor_neighbour_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                cfg_rd_o[(i+1)*8 + 7] && (cfg_rd_o[(i+1)*8 + 3 +: 2] == 2'b01)
                |=> $stable(addr_rd_o[i*WW +: WW]));
        end
    end

endmodule

bind pmp_guard pmp_guard_chk #(.NREG(NREG), .AW(AW)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_allow_o  (rsp_allow_o),
    .cfg_wr_ok_o  (cfg_wr_ok_o),
    .addr_wr_ok_o (addr_wr_ok_o),
    .cfg_rd_o     (cfg_rd_o),
    .addr_rd_o    (addr_rd_o),
    .sec_en_o     (sec_en_o)
);

// File: tb/sim_pmp_guard.sv
`timescale 1ns/1ps
module sim_pmp_guard;

    localparam int NREG = 8;
    localparam int AW   = 32;
    localparam int WW   = AW - 2;

    logic                 clk_i = 1'b0;
    logic                 rst_ni = 1'b0;
    logic [NREG-1:0]      cfg_we_i = '0;
    logic [7:0]           cfg_wdata_i = '0;
    logic [NREG-1:0]      addr_we_i = '0;
    logic [WW-1:0]        addr_wdata_i = '0;
    logic                 sec_we_i = 1'b0;
    logic                 sec_wdata_i = 1'b0;
    logic                 req_valid_i = 1'b0;
    logic [AW-1:0]        req_addr_i = '0;
    logic [1:0]           req_type_i = '0;
    logic                 req_priv_i = 1'b0;
    logic                 rsp_valid_o, rsp_allow_o, sec_en_o;
    logic [NREG-1:0]      cfg_wr_ok_o, addr_wr_ok_o;
    logic [NREG*8-1:0]    cfg_rd_o;
    logic [NREG*WW-1:0]   addr_rd_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk_i = ~clk_i;

    pmp_guard #(.NREG(NREG), .AW(AW)) u0 (
        .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .addr_we_i, .addr_wdata_i,
        .sec_we_i, .sec_wdata_i, .req_valid_i, .req_addr_i, .req_type_i,
        .req_priv_i, .rsp_valid_o, .rsp_allow_o, .cfg_wr_ok_o, .addr_wr_ok_o,
        .cfg_rd_o, .addr_rd_o, .sec_en_o
    );

    localparam logic [1:0] RD = 2'b00, WR = 2'b01, EX = 2'b10, RS = 2'b11;
    localparam logic M = 1'b1, U = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input int i, input logic [7:0] v);
        cfg_we_i[i] = 1'b1; cfg_wdata_i = v;
        @(posedge clk_i); @(negedge clk_i);
        cfg_we_i = '0;
    endtask

    task automatic wr_addr(input int i, input logic [WW-1:0] v);
        addr_we_i[i] = 1'b1; addr_wdata_i = v;
        @(posedge clk_i); @(negedge clk_i);
        addr_we_i = '0;
    endtask

    task automatic wr_sec(input logic v);
        sec_we_i = 1'b1; sec_wdata_i = v;
        @(posedge clk_i); @(negedge clk_i);
        sec_we_i = 1'b0;
    endtask

    task automatic acc(input string tag, input logic [AW-1:0] a, input logic [1:0] t,
                       input logic p, input logic exp);
        req_valid_i = 1'b1; req_addr_i = a; req_type_i = t; req_priv_i = p;
        @(posedge clk_i); @(negedge clk_i);
        req_valid_i = 1'b0;
        chk({tag, " R12 valid"}, 64'(rsp_valid_o), 64'd1);
        chk(tag, 64'(rsp_allow_o), 64'(exp));
    endtask

    task automatic t_reset;
        chk("R5 cfg reset", 64'(cfg_rd_o), 64'd0);
        chk("R10 enable reset", 64'(sec_en_o), 64'd0);
        chk("R12 idle valid", 64'(rsp_valid_o), 64'd0);
        chk("R5 cfg writable", 64'(cfg_wr_ok_o), 64'hFF);
        chk("R5 addr writable", 64'(addr_wr_ok_o), 64'hFF);
        acc("R1 user open", 32'h1234_5678, WR, U, 1'b1);
        acc("R1 machine open", 32'h0000_0040, EX, M, 1'b1);
        @(negedge clk_i);
        chk("R12 drop after response", 64'(rsp_valid_o), 64'd0);
    endtask

    task automatic t_tor;
        wr_addr(0, 30'h400);
        wr_cfg(0, 8'h09);                       // TOR, read only
        acc("R9 tor inside read", 32'h0000_0FFC, RD, U, 1'b1);
        acc("R7 write bit clear", 32'h0000_0FFC, WR, U, 1'b0);
        acc("R7 fetch bit clear", 32'h0000_0000, EX, U, 1'b0);
        acc("R2 user no match", 32'h0000_1000, RD, U, 1'b0);
        acc("R2 machine no match", 32'h0000_1000, RD, M, 1'b1);
        acc("R3 machine unlocked", 32'h0000_0FFC, WR, M, 1'b1);
        wr_addr(1, 30'h800);
        wr_cfg(1, 8'h0F);                       // TOR, rwx
        acc("R9 tor lower bound", 32'h0000_1800, WR, U, 1'b1);
        acc("R9 tor top excluded", 32'h0000_2000, WR, U, 1'b0);
        acc("R7 reserved kind", 32'h0000_1800, RS, U, 1'b0);
    endtask

    task automatic t_napot;
        wr_addr(2, 30'h1003);                   // 32 bytes at 0x4000
        wr_cfg(2, 8'h1C);                       // NAPOT, fetch only
        acc("R9 napot last word", 32'h0000_401C, EX, U, 1'b1);
        acc("R9 napot past end", 32'h0000_4020, EX, U, 1'b0);
        acc("R7 napot read denied", 32'h0000_4000, RD, U, 1'b0);
        wr_addr(3, 30'h1FF);                    // 4 KiB at 0
        wr_cfg(3, 8'h1F);                       // NAPOT, rwx
        acc("R8 lower index wins", 32'h0000_0010, WR, U, 1'b0);
        acc("R8 shared read", 32'h0000_0010, RD, U, 1'b1);
    endtask

    task automatic t_lock;
        wr_addr(4, 30'h2000);                   // 8 bytes at 0x8000
        wr_cfg(4, 8'h99);                       // locked NAPOT, read only
        acc("R4 machine bound write", 32'h0000_8000, WR, M, 1'b0);
        acc("R4 machine bound read", 32'h0000_8004, RD, M, 1'b1);
        chk("R5 cfg gate", 64'(cfg_wr_ok_o[4]), 64'd0);
        wr_cfg(4, 8'h00);
        chk("R5 cfg held", 64'(cfg_rd_o[4*8 +: 8]), 64'h99);
        wr_addr(4, 30'h1234);
        chk("R5 addr held", 64'(addr_rd_o[4*WW +: WW]), 64'h2000);
        acc("R5 rule still active", 32'h0000_8000, WR, M, 1'b0);
        wr_addr(5, 30'h2800);
        wr_addr(6, 30'h2C00);
        wr_cfg(6, 8'h89);                       // locked TOR, read only
        chk("R6 neighbour gate", 64'(addr_wr_ok_o[5]), 64'd0);
        chk("R6 neighbour cfg open", 64'(cfg_wr_ok_o[5]), 64'd1);
        chk("R6 upper region open", 64'(addr_wr_ok_o[7]), 64'd1);
        wr_addr(5, 30'h0);
        chk("R6 neighbour addr held", 64'(addr_rd_o[5*WW +: WW]), 64'h2800);
        acc("R6 tor range kept", 32'h0000_A800, WR, M, 1'b0);
    endtask

    task automatic t_extended;
        wr_sec(1'b1);
        chk("R10 enable set", 64'(sec_en_o), 64'd1);
        wr_sec(1'b0);
        chk("R10 enable sticky", 64'(sec_en_o), 64'd1);
        acc("R11 machine denied user rule", 32'h0000_0010, RD, M, 1'b0);
        acc("R11 user rule read", 32'h0000_0010, RD, U, 1'b1);
        acc("R11 user denied machine rule", 32'h0000_8000, RD, U, 1'b0);
        acc("R11 machine rule read", 32'h0000_8000, RD, M, 1'b1);
        acc("R11 machine rule write", 32'h0000_8000, WR, M, 1'b0);
        acc("R2 machine no match ext", 32'h0000_5000, RD, M, 1'b1);
        acc("R2 user no match ext", 32'h0000_5000, RD, U, 1'b0);
    endtask

    task automatic t_rereset;
        rst_ni = 1'b0;
        @(posedge clk_i); @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R5 lock cleared", 64'(cfg_rd_o), 64'd0);
        chk("R5 addr cleared", 64'(addr_rd_o[6*WW +: WW]), 64'd0);
        chk("R10 enable cleared", 64'(sec_en_o), 64'd0);
        chk("R5 writable again", 64'(cfg_wr_ok_o), 64'hFF);
        acc("R1 open after reset", 32'h0000_8000, WR, U, 1'b1);
    endtask

    initial begin
        #(200_000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_tor();
        t_napot();
        t_lock();
        t_extended();
        t_rereset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule